// File: doc/BRIEF.md
# Subranging SAR Conversion Sequencer

This block is the digital controller of a multi-step subranging successive-approximation converter whose decision element is a 4-bit flash quantizer rather than a single comparator. A start pulse launches a fixed five-step sequence. In each step the sequencer waits a number of settle cycles, samples the flash code, folds it into a running 14-bit value with overlap correction and saturation, and writes that value to the DAC drive word so that the residue seen by the next step becomes smaller.

Each step also sets its own analog configuration: a finer flash range, a high-gain residue path, a bandwidth limit, a quarter range and a bias change. These strobes fall back to their step-one state (all low) whenever the sequencer is idle. After the fifth step the result is registered and end-of-conversion pulses for one clock.

Top module: `sars_conv_seq`

## Requirements
- R1: After reset, busy, eoc, all five control strobes, result and dac_word are all zero.
- R2: A start seen while idle makes busy high from the next clock. The conversion has five steps of exactly SETTLE_CYCLES clocks each, so busy stays high for 5*SETTLE_CYCLES clocks. eoc is high in the first cycle with busy low.
- R3: Step 1 (index 0) reads the 4-bit code f as unsigned and adds f*2048 to a running value that starts at zero.
- R4: Steps 2, 3 and 4 read the code as (f-4), a signed value with an overlap of one group bit, and add it times 256, 32 and 4 respectively. A negative term lowers the previous group's LSB.
- R5: Step 5 adds floor((f-4)/2), which supplies the last two result bits.
- R6: After every step the running value is clamped to the range 0..16383.
- R7: dac_word is zero at the start of step 1 and, after each step, equals the running value produced by that step. It does not change between steps.
- R8: Strobe pattern by step: step 1 none; step 2 res_fine; step 3 gain_hi only; step 4 res_fine and bw_lim; step 5 range_quarter and bias_shift. The steps occur in this order.
- R9: All strobes are low whenever busy is low.
- R10: A start while busy is ignored. Both the conversion length and the result are unchanged.
- R11: eoc is a single-cycle pulse. result holds its value until the next conversion ends.
- R12: When each step's flash code is the ideal quantization of the residue, with comparator offsets up to a quarter of that step's weight in steps 1 to 4, the result equals the input exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, sampled when idle |
| flash_code | input | 4 | Flash quantizer output for the current step |
| dac_word | output | 14 | DAC drive word (running value) |
| res_fine | output | 1 | Flash range eight times finer |
| gain_hi | output | 1 | High-gain residue amplifier path |
| bw_lim | output | 1 | Residue bandwidth limit |
| range_quarter | output | 1 | Further range reduction by four |
| bias_shift | output | 1 | Alternate residue bias |
| result | output | 14 | Final conversion result |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | One-cycle end-of-conversion pulse |

## Verification
A wrong step index or settle counter shows up at once on the strobe outputs. The strobe pattern is unique for each step, so a skipped, repeated or stretched step appears within one step time as a bad pattern order or a wrong step length. A corrupted running value shows up on dac_word at the next step boundary, well before eoc. The bench compares dac_word against its own arithmetic at every boundary. Wrong overlap or saturation arithmetic, which would otherwise hide until the end, is therefore caught at the first step where it goes wrong.

// File: rtl/sars_pkg.sv
package sars_pkg;
    localparam int RES_W     = 14;
    localparam int FL_W      = 4;
    localparam int GRP_W     = 3;
    localparam int N_STEPS   = 5;
    localparam int STEP_W    = $clog2(N_STEPS);
    localparam int OVL_OFS   = 4;
    localparam int ACC_W     = RES_W + FL_W;
    localparam int TOP_SHIFT = RES_W - GRP_W;

    localparam logic [RES_W-1:0]        FULL   = '1;
    localparam logic signed [ACC_W-1:0] FULL_S = ACC_W'((1 << RES_W) - 1);

    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        logic res_fine;
        logic gain_hi;
        logic bw_lim;
        logic range_quarter;
        logic bias_shift;
    } actl_t;

    typedef enum logic { SQ_IDLE, SQ_RUN } sq_e;

    // Analog configuration for each step of the sequence
    function automatic actl_t ctl_for_step(step_t s);
        actl_t c;
        c = '0;
        case (s)
            step_t'(1): c.res_fine = 1'b1;
            step_t'(2): c.gain_hi  = 1'b1;
            step_t'(3): begin
                c.res_fine = 1'b1;
                c.bw_lim   = 1'b1;
            end
            step_t'(4): begin
                c.range_quarter = 1'b1;
                c.bias_shift    = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    // Signed term a flash code adds in a given step
    function automatic logic signed [ACC_W-1:0] step_term(step_t s, logic [FL_W-1:0] f);
        logic signed [ACC_W-1:0] v;
        v = $signed({{(ACC_W-FL_W){1'b0}}, f});
        if (s != '0)
            v = v - $signed(ACC_W'(OVL_OFS));
        if (s == step_t'(N_STEPS-1))
            v = v >>> 1;
        else
            v = v <<< (TOP_SHIFT - GRP_W * int'(s));
        return v;
    endfunction

    function automatic logic [RES_W-1:0] sat_code(logic signed [ACC_W-1:0] v);
        if (v < 0)
            return '0;
        if (v > FULL_S)
            return FULL;
        return v[RES_W-1:0];
    endfunction
endpackage

// File: rtl/sars_seq_ctrl.sv
module sars_seq_ctrl
    import sars_pkg::*;
#(
    parameter int SETTLE = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output logic  busy,
    output step_t step,
    output logic  sample,
    output logic  last,
    output logic  launch
);
    localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SETTLE - 1);
    localparam step_t LAST_STEP = step_t'(N_STEPS - 1);

    sq_e             st;
    logic [CNT_W-1:0] cnt;

    assign busy   = (st == SQ_RUN);
    assign launch = start && !busy;
    assign sample = busy && (cnt == CNT_END);
    assign last   = sample && (step == LAST_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SQ_IDLE;
            step <= '0;
            cnt  <= '0;
        end else if (launch) begin
            st   <= SQ_RUN;
            step <= '0;
            cnt  <= '0;
        end else if (busy) begin
            if (sample) begin
                cnt <= '0;
                if (last) begin
                    st   <= SQ_IDLE;
                    step <= '0;
                end else begin
                    step <= step + step_t'(1);
                end
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    AST_LAUNCH_ENTRY: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy && step == '0) else $error("launch did not begin step 1"); // R2
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (sample && !last) |=> step == $past(step) + step_t'(1)) else $error("step skipped"); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt <= CNT_END) else $error("settle counter overran"); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !sample) |=> step == $past(step)) else $error("start while busy acted"); // R10
endmodule

// File: rtl/sars_accum.sv
module sars_accum
    import sars_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             sample,
    input  step_t            step,
    input  logic [FL_W-1:0]  flash,
    output logic [RES_W-1:0] acc_q,
    output logic [RES_W-1:0] acc_nxt
);
    logic signed [ACC_W-1:0] sum;

    always_comb begin
        sum     = $signed({{(ACC_W-RES_W){1'b0}}, acc_q}) + step_term(step, flash);
        acc_nxt = sat_code(sum);
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            acc_q <= '0;
        else if (sample)
            acc_q <= acc_nxt;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear |=> acc_q == '0) else $error("running value not cleared"); // R7
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sample && !clear) |=> $stable(acc_q)) else $error("running value moved between steps"); // R7
    AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
        (sample && sum > FULL_S) |=> acc_q == FULL) else $error("no clamp at full scale"); // R6
    AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        (sample && sum < 0) |=> acc_q == '0) else $error("no clamp at zero"); // R6
endmodule

// File: rtl/sars_conv_seq.sv
module sars_conv_seq
    import sars_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [FL_W-1:0]  flash_code,
    output logic [RES_W-1:0] dac_word,
    output logic             res_fine,
    output logic             gain_hi,
    output logic             bw_lim,
    output logic             range_quarter,
    output logic             bias_shift,
    output logic [RES_W-1:0] result,
    output logic             busy,
    output logic             eoc
);
    logic             busy_i, sample, last, launch;
    step_t            step;
    logic [RES_W-1:0] acc_q, acc_nxt, result_q;
    logic             eoc_q;
    actl_t            ctl;

    sars_seq_ctrl #(.SETTLE(SETTLE_CYCLES)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .busy   (busy_i),
        .step   (step),
        .sample (sample),
        .last   (last),
        .launch (launch)
    );

    sars_accum u_acc (
        .clk     (clk),
        .rst     (rst),
        .clear   (launch),
        .sample  (sample),
        .step    (step),
        .flash   (flash_code),
        .acc_q   (acc_q),
        .acc_nxt (acc_nxt)
    );

    always_comb ctl = busy_i ? ctl_for_step(step) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            eoc_q    <= 1'b0;
        end else begin
            eoc_q <= last;
            if (last)
                result_q <= acc_nxt;
        end
    end

    assign dac_word      = acc_q;
    assign res_fine      = ctl.res_fine;
    assign gain_hi       = ctl.gain_hi;
    assign bw_lim        = ctl.bw_lim;
    assign range_quarter = ctl.range_quarter;
    assign bias_shift    = ctl.bias_shift;
    assign result        = result_q;
    assign busy          = busy_i;
    assign eoc           = eoc_q;

    AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        eoc_q |=> !eoc_q) else $error("eoc longer than one cycle"); // R11
    AST_EOC_IDLE: assert property (@(posedge clk) disable iff (rst)
        eoc_q |-> !busy_i) else $error("eoc while busy"); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !eoc_q |-> $stable(result_q)) else $error("result moved without eoc"); // R11
    AST_BW_AFTER_GAIN: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.bw_lim) |-> $past(ctl.gain_hi)) else $error("bandwidth limit out of order"); // R8
    AST_RESULT_DAC: assert property (@(posedge clk) disable iff (rst)
        eoc_q |-> result_q == acc_q) else $error("result differs from final DAC word"); // R7
endmodule

// File: tb/sars_conv_seq_test.sv
module sars_conv_seq_test;
    localparam int SETTLE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  flash;
    logic [13:0] dac_word, result;
    logic        res_fine, gain_hi, bw_lim, range_quarter, bias_shift, busy, eoc;

    always #5 clk = ~clk;

    sars_conv_seq #(.SETTLE_CYCLES(SETTLE)) uut (
        .clk(clk), .rst(rst), .start(start), .flash_code(flash),
        .dac_word(dac_word), .res_fine(res_fine), .gain_hi(gain_hi),
        .bw_lim(bw_lim), .range_quarter(range_quarter), .bias_shift(bias_shift),
        .result(result), .busy(busy), .eoc(eoc)
    );

    typedef struct {
        int    res;
        int    x;
        bit    exact;
        string tag;
    } exp_t;

    exp_t expq[$];
    int   code_tab[5];
    int   acc_tab[5];
    int   n_chk = 0;
    int   n_bad = 0;
    int   done_cnt = 0;

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampi(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // Running-value arithmetic taken from R3..R6
    function automatic int ref_step(int acc, int k, int f);
        int v;
        if (k == 0)      v = f * 2048;
        else if (k < 4)  v = (f - 4) * (1 << (11 - 3 * k));
        else             v = (f - 4) >>> 1;
        return clampi(acc + v, 0, 16383);
    endfunction

    function automatic int dec_ctl(logic [4:0] v);
        case (v)
            5'b00000: return 0;
            5'b10000: return 1;
            5'b01000: return 2;
            5'b10100: return 3;
            5'b00011: return 4;
            default:  return 9;
        endcase
    endfunction

    // Flash source: the step is recognised from the strobe pattern (R8)
    always_comb begin
        flash = 4'd0;
        if (busy) begin
            case ({res_fine, gain_hi, bw_lim, range_quarter, bias_shift})
                5'b00000: flash = 4'(code_tab[0]);
                5'b10000: flash = 4'(code_tab[1]);
                5'b01000: flash = 4'(code_tab[2]);
                5'b10100: flash = 4'(code_tab[3]);
                5'b00011: flash = 4'(code_tab[4]);
                default:  flash = 4'd0;
            endcase
        end
    end

    task automatic convert(int exp_res, int x, bit exact, string tag, bit poke);
        exp_t e;
        int   d0;
        logic [13:0] held;
        e.res = exp_res; e.x = x; e.exact = exact; e.tag = tag;
        expq.push_back(e);
        d0 = done_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
            repeat (SETTLE) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        wait (done_cnt != d0);
        held = result;
        @(negedge clk);
        check(!eoc, "R11 eoc single cycle", int'(eoc), 0);
        repeat (5) @(negedge clk);
        check(result == held, "R11 result held", int'(result), int'(held));
    endtask

    // Behavioural residue model with per-step comparator offsets
    task automatic run_analog(int x, int o0, int o1, int o2, int o3, string tag, bit poke);
        int acc, r, f;
        int off[4];
        off[0] = o0; off[1] = o1; off[2] = o2; off[3] = o3;
        acc = 0;
        for (int k = 0; k < 5; k++) begin
            r = x - acc;
            if (k == 0)     f = (r + off[0]) >>> 11;
            else if (k < 4) f = ((r + off[k]) >>> (11 - 3 * k)) + 4;
            else            f = 2 * r + 4;
            f = clampi(f, 0, 15);
            code_tab[k] = f;
            acc = ref_step(acc, k, f);
            acc_tab[k] = acc;
        end
        convert(acc, x, 1'b1, tag, poke);
    endtask

    task automatic run_codes(int c0, int c1, int c2, int c3, int c4, string tag);
        int acc;
        code_tab[0] = c0; code_tab[1] = c1; code_tab[2] = c2;
        code_tab[3] = c3; code_tab[4] = c4;
        acc = 0;
        for (int k = 0; k < 5; k++) begin
            acc = ref_step(acc, k, code_tab[k]);
            acc_tab[k] = acc;
        end
        convert(acc, 0, 1'b0, tag, 1'b0);
    endtask

    // Monitor: step boundaries, DAC word, strobes and results
    initial begin
        int   prev, cnt, bcyc, cur, nexp;
        exp_t e;
        prev = -1; cnt = 0; bcyc = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev = -1; cnt = 0; bcyc = 0;
            end else begin
                cur = busy ? dec_ctl({res_fine, gain_hi, bw_lim, range_quarter, bias_shift}) : -1;
                if (busy) bcyc++;
                if (cur != prev) begin
                    if (prev >= 0 && prev < 5) begin
                        check(cnt == SETTLE, "R2 step length", cnt, SETTLE);
                        check(int'(dac_word) == acc_tab[prev], "R7 dac after step", int'(dac_word), acc_tab[prev]);
                    end
                    if (cur == 0)
                        check(dac_word == 14'd0, "R7 dac cleared", int'(dac_word), 0);
                    if (prev == -1)     nexp = 0;
                    else if (prev >= 4) nexp = -1;
                    else                nexp = prev + 1;
                    check(cur == nexp, "R8 step order", cur, nexp);
                    cnt = 1;
                    prev = cur;
                end else begin
                    cnt++;
                end
                if (eoc) begin
                    check(!busy, "R2 eoc after busy", int'(busy), 0);
                    check(bcyc == 5 * SETTLE, "R2 busy length", bcyc, 5 * SETTLE);
                    check({res_fine, gain_hi, bw_lim, range_quarter, bias_shift} == 5'b0,
                          "R9 idle strobes", int'({res_fine, gain_hi, bw_lim, range_quarter, bias_shift}), 0);
                    if (expq.size() == 0) begin
                        check(1'b0, "R2 unexpected eoc", 1, 0);
                    end else begin
                        e = expq.pop_front();
                        check(int'(result) == e.res, e.tag, int'(result), e.res);
                        if (e.exact)
                            check(int'(result) == e.x, "R12 exact result", int'(result), e.x);
                    end
                    bcyc = 0;
                    done_cnt++;
                end
            end
        end
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 5; k++) begin
            code_tab[k] = 0;
            acc_tab[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !eoc, "R1 reset flags", int'({busy, eoc}), 0);
        check(result == 14'd0, "R1 reset result", int'(result), 0);
        check(dac_word == 14'd0, "R1 reset dac", int'(dac_word), 0);
        check({res_fine, gain_hi, bw_lim, range_quarter, bias_shift} == 5'b0,
              "R9 strobes after reset", int'({res_fine, gain_hi, bw_lim, range_quarter, bias_shift}), 0);

        run_analog(0,     0,    0,   0,  0, "R3 zero input", 1'b0);
        run_analog(16383, 0,    0,   0,  0, "R3 full input", 1'b0);
        run_analog(12345, 400, -50,  7, -1, "R4 overlap correction", 1'b0);
        run_analog(5000, -500,  60, -8,  1, "R4 negative correction", 1'b0);
        run_analog(777,  -300,  30,  5, -1, "R10 start while busy", 1'b1);
        run_analog(9999,  256, -64,  8,  1, "R5 final bits", 1'b0);
        run_codes(15, 15, 15, 15, 15, "R6 clamp high");
        run_codes(0, 0, 0, 0, 0, "R6 clamp low");
        run_codes(7, 15, 0, 9, 13, "R6 clamp mid conversion");
        run_codes(3, 4, 4, 4, 4, "R3 step one weight");
        run_codes(0, 5, 6, 7, 5, "R4 group weights");
        run_codes(2, 4, 4, 4, 1, "R5 negative final term");

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule